// File: doc/BRIEF.md
# Block-Structured Boot Loader

This block sits behind a serial word receiver during boot and turns a stream of 32-bit words into memory writes. The stream is a chain of load blocks. Each block starts with a count of data words, then a destination address, then exactly that many data words. The block writes each data word to the next address in a simple write port: write enable, address and data.

A count of zero closes the load and sets a sticky done flag. No address word follows a zero count. Any number of blocks may be chained, including very short ones that carry a single word. The destination address of the first block that carries data is kept and reported as the entry address once the load is done. The stream holds only block words; any memory-interface setup words are removed before they reach this block.

Words arrive on a valid/word pair. A cycle with valid low carries no word, so the sender may leave gaps of any length between words. After done, incoming words are ignored until a synchronous reset.

Top module: `blk_loader`

## Requirements
- R1: While and after reset, done is low, mem_we is low and entry_addr is zero.
- R2: The first accepted word after reset, and the first accepted word after the last data word of a block, is a length. If its low LEN_W bits are nonzero, the next accepted word is taken as the block's start address (its low ADDR_W bits).
- R3: The i-th data word of a block (i counting from 0) is written with mem_addr equal to the start address plus i, modulo 2^ADDR_W, and mem_wdata equal to the word. mem_we is high for exactly the one cycle that follows the cycle in which the word was accepted.
- R4: A block produces exactly as many writes as its length word. The word after its last data word is read as a new length, so blocks chain, and a block with a length of one is legal.
- R5: A length word of zero raises done on the following cycle. Done stays high until reset.
- R6: entry_addr is zero while done is low. While done is high, it holds the start address of the first block with a nonzero length, or zero if no such block was received.
- R7: Words accepted while done is high cause no write and do not change entry_addr.
- R8: A cycle with in_valid low is not a word: it causes no write and does not advance the parsing.
- R9: A synchronous reset in the middle of a block discards the partial block, and the next word is treated as a length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_word carries a word this cycle |
| in_word | input | WORD_W | Received stream word |
| mem_we | output | 1 | Memory write strobe, one cycle per data word |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | WORD_W | Memory write data |
| done | output | 1 | Load finished (sticky until reset) |
| entry_addr | output | ADDR_W | Start address of the first non-empty block, valid with done |

## Verification
The checker tests the properties that hold in every cycle:
- a write strobe only ever follows an accepted word;
- back-to-back writes go to adjacent addresses;
- done never falls, and no write occurs while it is high;
- entry_addr stays zero before done and stays still after it.

Other behaviour can only be shown by the bench's scenarios:
- the exact split of the stream into length, address and data words;
- that a block gives exactly as many writes as its length;
- that a one-word block is handled, and that the entry address comes from the first block rather than a later one;
- that gaps and a mid-block reset are absorbed.

// File: rtl/blk_loader_pkg.sv
package blk_loader_pkg;

  typedef enum logic [1:0] {
    ST_LEN  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } ld_state_t;

endpackage

// File: rtl/blk_loader_ctrl.sv
module blk_loader_ctrl
  import blk_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              take_addr,
  output logic              take_data,
  output logic              finish,
  output logic              done
);

  ld_state_t        state_q;
  logic [LEN_W-1:0] remain_q;
  logic             done_q;
  logic [LEN_W-1:0] len_field;

  assign len_field = in_word[LEN_W-1:0];

  assign take_addr = in_valid && (state_q == ST_ADDR);
  assign take_data = in_valid && (state_q == ST_DATA);
  assign finish    = in_valid && (state_q == ST_LEN) && (len_field == '0);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_LEN;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else if (in_valid) begin
      unique case (state_q)
        ST_LEN: begin
          if (len_field == '0) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else begin
            remain_q <= len_field;
            state_q  <= ST_ADDR;
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) state_q <= ST_LEN;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/blk_loader_wport.sv
module blk_loader_wport #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_addr,
  input  logic              take_data,
  input  logic              finish,
  input  logic [WORD_W-1:0] in_word,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] entry_addr
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] entry_q;
  logic              entry_set_q;
  logic [ADDR_W-1:0] entry_out_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= '0;
      entry_q     <= '0;
      entry_set_q <= 1'b0;
      entry_out_q <= '0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      we_q <= take_data;
      if (take_addr) begin
        ptr_q <= in_word[ADDR_W-1:0];
        if (!entry_set_q) begin
          entry_q     <= in_word[ADDR_W-1:0];
          entry_set_q <= 1'b1;
        end
      end
      if (take_data) begin
        addr_q  <= ptr_q;
        wdata_q <= in_word;
        ptr_q   <= ptr_q + 1'b1;
      end
      if (finish) entry_out_q <= entry_q;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign entry_addr = entry_out_q;

endmodule

// File: rtl/blk_loader.sv
module blk_loader #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] entry_addr
);

  logic take_addr;
  logic take_data;
  logic finish;

  blk_loader_ctrl #(
    .WORD_W(WORD_W),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .take_addr(take_addr),
    .take_data(take_data),
    .finish   (finish),
    .done     (done)
  );

  blk_loader_wport #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_wport (
    .clk       (clk),
    .rst       (rst),
    .take_addr (take_addr),
    .take_data (take_data),
    .finish    (finish),
    .in_word   (in_word),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .entry_addr(entry_addr)
  );

endmodule

// File: rtl/blk_loader_chk.sv
module blk_loader_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [ADDR_W-1:0] entry_addr
);

  // R3 R8
  write_follows_word_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(in_valid));

  // R3
  adjacent_write_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R7
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  // R6
  entry_zero_early_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (entry_addr == '0));

  // R6 R7
  entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(entry_addr));

endmodule

bind blk_loader blk_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .done      (done),
  .entry_addr(entry_addr)
);

// File: tb/blk_loader_bench.sv
module blk_loader_bench;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 24;
  localparam int NS = 14;
  localparam int NW = 6;

  // stream: 1-word block at 0x809800, 3-word block at 0x809802,
  // 2-word block at 0x000100, terminator
  localparam logic [31:0] STREAM [0:NS-1] = '{
    32'd1, 32'h00809800, 32'h00000000,
    32'd3, 32'h00809802, 32'h10800001, 32'h50700080, 32'h08601018,
    32'd2, 32'h00000100, 32'hCAFE0001, 32'hCAFE0002,
    32'd0, 32'd0
  };
  localparam logic [23:0] EXP_A [0:NW-1] = '{
    24'h809800, 24'h809802, 24'h809803, 24'h809804, 24'h000100, 24'h000101
  };
  localparam logic [31:0] EXP_D [0:NW-1] = '{
    32'h00000000, 32'h10800001, 32'h50700080, 32'h08601018,
    32'hCAFE0001, 32'hCAFE0002
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic              done;
  logic [ADDR_W-1:0] entry_addr;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [ADDR_W-1:0] cap_a [0:15];
  logic [WORD_W-1:0] cap_d [0:15];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  blk_loader u_blk_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .entry_addr(entry_addr)
  );

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (wr_cnt < 16) begin
        cap_a[wr_cnt] = mem_addr;
        cap_d[wr_cnt] = mem_wdata;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'hDEADBEEF;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", 64'(done), 64'd0);
    check("R1 mem_we", 64'(mem_we), 64'd0);
    check("R1 entry_addr", 64'(entry_addr), 64'd0);
    rst = 1'b0;

    // table walk, idle gaps after odd words (R8); stop before terminator
    for (int i = 0; i < NS - 2; i++) begin
      send(STREAM[i]);
      if (i % 2 == 1) repeat (2) @(negedge clk);
    end
    check("R5 done low before terminator", 64'(done), 64'd0);
    check("R6 entry zero before done", 64'(entry_addr), 64'd0);
    send(STREAM[NS-2]);
    check("R5 done after zero length", 64'(done), 64'd1);
    check("R4 R8 write count", 64'(wr_cnt), 64'(NW));
    for (int k = 0; k < NW; k++) begin
      check("R2 R3 write addr", 64'(cap_a[k]), 64'(EXP_A[k]));
      check("R3 R4 write data", 64'(cap_d[k]), 64'(EXP_D[k]));
    end
    check("R6 entry first block", 64'(entry_addr), 64'h809800);

    // R7 words after done are ignored
    send(32'd2); send(32'h00000055); send(32'h11111111); send(32'h22222222);
    repeat (2) @(negedge clk);
    check("R7 no writes after done", 64'(wr_cnt), 64'(NW));
    check("R7 entry unchanged", 64'(entry_addr), 64'h809800);
    check("R5 done sticky", 64'(done), 64'd1);

    // R3 write strobe timing
    do_reset();
    check("R1 done cleared", 64'(done), 64'd0);
    send(32'd1);
    send(32'h00FFFFFF);
    check("R3 no write on address word", 64'(mem_we), 64'd0);
    send(32'hABCD0123);
    check("R3 strobe cycle after word", 64'(mem_we), 64'd1);
    check("R3 wrap addr", 64'(mem_addr), 64'hFFFFFF);
    @(negedge clk);
    check("R3 strobe one cycle", 64'(mem_we), 64'd0);

    // R9 reset mid-block then empty load
    do_reset();
    send(32'd4); send(32'h00000200); send(32'h01010101);
    do_reset();
    send(32'd0);
    check("R9 zero after reset ends load", 64'(done), 64'd1);
    check("R9 no writes", 64'(wr_cnt), 64'd0);
    check("R6 entry zero with no data block", 64'(entry_addr), 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule